// File: doc/BRIEF.md
# Temperature Sensor Alarm Register File

This block is the device-side register file of a memory-module temperature sensor. It sits behind a byte-wide register port that a serial target engine drives. It returns fixed identification bytes and holds a sensor-disable bit, four signed alarm limits and the most recent temperature sample. It also keeps four sticky alarm flags, which software clears by writing a mask.

Each accepted sample is an 11-bit two's-complement value in quarter-degree steps. The block stores the sample and compares it, as a signed value, against the high, low, critical-high and critical-low limits. Any limit that the sample crosses sets its flag. A flag stays set until software clears it, and it sets again on the next sample if the condition still holds. Register reads return their data one cycle after the request.

Top module: `tsense_regfile`

## Requirements
- R1: Identification reads are constant. Address 0x00 returns 0x51 and 0x01 returns 0x18. Address 0x05 returns 0x02, which means sensor present with bits 7:2 at zero. Address 0x02 returns {2'b00, major-1 in 5:4, minor-1 in 3:1, 1'b0}, which is 0x02 by default. Addresses 0x03 and 0x04 return a bank byte and an ID byte, each with seven data bits and an odd-parity bit in bit 7. The defaults are bank 0x00 and ID 0x2C, so the bytes read 0x80 and 0x2C.
- R2: A read request at a rising edge makes rd_valid high with rd_data for that address after that edge, and rd_valid is low in any cycle with no request.
- R3: The limit bytes sit low byte first at even addresses: high at 0x1C/0x1D, low at 0x1E/0x1F, critical high at 0x20/0x21 and critical low at 0x22/0x23. A word holds the 11-bit value in bits 12:2, so writes to a low byte keep bits 7:2, with bits 1:0 reading 0. Writes to a high byte keep bits 4:0, with bits 7:5 reading 0.
- R4: While the sensor is enabled, a sample pulse loads the sample into the temperature word at 0x31 (low byte) and 0x32 (high byte), in the same format as the limits.
- R5: Status bit 0 (address 0x33) sets on a sample that is strictly greater than the high limit.
- R6: Status bit 1 sets on a sample that is strictly less than the low limit.
- R7: Status bit 2 sets on a sample greater than the critical-high limit, and bit 3 sets on a sample less than the critical-low limit. All comparisons are signed.
- R8: A set status bit stays set when later samples no longer meet its condition.
- R9: Writing a mask to 0x13 clears the status bits where the mask is 1. A bit whose condition still holds sets again on the next sample. Addresses 0x13 and 0x14 read as 0x00.
- R10: Bit 0 of the configuration register at 0x1A disables the sensor, and the register reads back only that bit. While the sensor is disabled, sample pulses change neither the temperature word nor any status bit.
- R11: Writes to any address other than 0x13, 0x1A and 0x1C–0x23 have no effect, and reads of unmapped addresses return 0x00.
- R12: After reset, the limits, the temperature word, the status register and the configuration register all read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register address for the read or write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| smp_valid | input | 1 | New temperature sample pulse |
| smp_temp | input | 11 | Sample, signed, 0.25 degree units |

## Verification
The alarm comparisons are tried with samples exactly at each limit and one step past it. This separates the strict compare from one that includes equality. Negative samples against a mix of positive and negative limits separate a signed compare from an unsigned one. The full-scale samples, +1023 and −1024 steps, check the byte packing at the range ends. Sequences of sample, clear and repeated sample show that a flag is sticky, that a clear masks only its own bits, and that a flag sets again when its condition holds. With the sensor disabled, an alarming sample must leave both the temperature word and the status unchanged.

// File: rtl/tsense_regfile.sv
module tsense_regfile #(
  parameter logic [6:0] VENDOR_BANK  = 7'h00,
  parameter logic [6:0] VENDOR_ID    = 7'h2C,
  parameter logic [1:0] REV_MAJOR_M1 = 2'd0,
  parameter logic [2:0] REV_MINOR_M1 = 3'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic        smp_valid,
  input  logic [10:0] smp_temp
);
  localparam logic [7:0] A_TYPE0 = 8'h00, A_TYPE1 = 8'h01, A_REV = 8'h02;
  localparam logic [7:0] A_BANK = 8'h03, A_VID = 8'h04, A_CAP = 8'h05;
  localparam logic [7:0] A_CLR = 8'h13, A_ECLR = 8'h14, A_CFG = 8'h1A;
  localparam logic [7:0] A_THR = 8'h1C, A_THR_END = 8'h23;
  localparam logic [7:0] A_TLO = 8'h31, A_THI = 8'h32, A_STAT = 8'h33;
  localparam int NTHR = 4;

  logic signed [10:0] thr_q [NTHR];
  logic signed [10:0] temp_q;
  logic [3:0]  status_q;
  logic        dis_q;

  logic        thr_hit, take, clr_hit;
  logic [7:0]  toff;
  logic [1:0]  tidx;
  logic [3:0]  set_mask, clr_mask;
  logic [7:0]  rd_mux;
  logic signed [10:0] smp_s;

  assign smp_s   = smp_temp;
  assign toff    = addr - A_THR;
  assign tidx    = toff[2:1];
  assign thr_hit = (addr >= A_THR) && (addr <= A_THR_END);
  assign take    = smp_valid && !dis_q;
  assign clr_hit = wr_en && (addr == A_CLR);
  assign clr_mask = clr_hit ? wr_data[3:0] : 4'h0;
  assign set_mask = take ? {smp_s < thr_q[3], smp_s > thr_q[2],
                            smp_s < thr_q[1], smp_s > thr_q[0]} : 4'h0;

  function automatic logic [7:0] lo_byte(input logic [10:0] v);
    return {v[5:0], 2'b00};
  endfunction
  function automatic logic [7:0] hi_byte(input logic [10:0] v);
    return {3'b000, v[10:6]};
  endfunction

  always_comb begin
    rd_mux = 8'h00;
    if (thr_hit) begin
      rd_mux = addr[0] ? hi_byte(thr_q[tidx]) : lo_byte(thr_q[tidx]);
    end else begin
      case (addr)
        A_TYPE0: rd_mux = 8'h51;
        A_TYPE1: rd_mux = 8'h18;
        A_REV:   rd_mux = {2'b00, REV_MAJOR_M1, REV_MINOR_M1, 1'b0};
        A_BANK:  rd_mux = {~^VENDOR_BANK, VENDOR_BANK};
        A_VID:   rd_mux = {~^VENDOR_ID, VENDOR_ID};
        A_CAP:   rd_mux = 8'h02;
        A_CFG:   rd_mux = {7'b0, dis_q};
        A_TLO:   rd_mux = lo_byte(temp_q);
        A_THI:   rd_mux = hi_byte(temp_q);
        A_STAT:  rd_mux = {4'b0, status_q};
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) thr_q[i] <= '0;
      temp_q   <= '0;
      status_q <= '0;
      dis_q    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en && thr_hit) begin
        if (addr[0]) thr_q[tidx][10:6] <= wr_data[4:0];
        else         thr_q[tidx][5:0]  <= wr_data[7:2];
      end
      if (wr_en && addr == A_CFG) dis_q <= wr_data[0];
      if (take) temp_q <= smp_s;
      status_q <= (status_q & ~clr_mask) | set_mask;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

module tsense_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  addr,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic        rd_en,
  input logic        rd_valid,
  input logic        smp_valid,
  input logic        dis_q,
  input logic [10:0] temp_q,
  input logic [3:0]  status_q
);
  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h13) |=> ((status_q & $past(status_q)) == $past(status_q)));
  a_r9_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h13 && !(smp_valid && !dis_q)) |=> ((status_q & $past(wr_data[3:0])) == 4'h0));
  a_r10_disabled_temp_held: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> $stable(temp_q));
  a_r10_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> ((status_q & ~$past(status_q)) == 4'h0));
  a_r4_no_sample_temp_held: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(temp_q));
endmodule

bind tsense_regfile tsense_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_valid(rd_valid), .smp_valid(smp_valid),
  .dis_q(dis_q), .temp_q(temp_q), .status_q(status_q)
);

// File: tb/tb_tsense_regfile.sv
`timescale 1ns/1ps
module tb_tsense_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wr_data = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, smp_valid = 1'b0;
  logic [10:0] smp_temp = '0;
  logic [7:0] rd_data;
  logic rd_valid;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  tsense_regfile dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .smp_valid(smp_valid), .smp_temp(smp_temp));

  function automatic logic [7:0] tlo(input int t);
    logic [10:0] v = t[10:0];
    return {v[5:0], 2'b00};
  endfunction
  function automatic logic [7:0] thi(input int t);
    logic [10:0] v = t[10:0];
    return {3'b000, v[10:6]};
  endfunction

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic smp(input int t);
    smp_temp = t[10:0]; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
  endtask
  task automatic set_thr(input logic [7:0] base, input int t);
    wr(base, tlo(t)); wr(base + 8'd1, thi(t));
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++; $display("FAIL unexpected rd_valid R2 actual=%02h expected=none", rd_data);
      end else begin
        logic [7:0] e; string tg;
        e = exp_q.pop_front(); tg = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++; $display("FAIL %s actual=%02h expected=%02h", tg, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    for (int a = 8'h1C; a <= 8'h23; a++) rd(a[7:0], 8'h00, "R12 limit reset");
    rd(8'h31, 8'h00, "R12 temp lo"); rd(8'h32, 8'h00, "R12 temp hi");
    rd(8'h33, 8'h00, "R12 status"); rd(8'h1A, 8'h00, "R12 config");
    // R1 identification
    rd(8'h00, 8'h51, "R1 type0"); rd(8'h01, 8'h18, "R1 type1");
    rd(8'h02, 8'h02, "R1 revision"); rd(8'h03, 8'h80, "R1 bank");
    rd(8'h04, 8'h2C, "R1 vendor id"); rd(8'h05, 8'h02, "R1 capability");
    // R3 byte masking
    wr(8'h1C, 8'hFF); wr(8'h1D, 8'hFF);
    rd(8'h1C, 8'hFC, "R3 low byte mask"); rd(8'h1D, 8'h1F, "R3 high byte mask");
    set_thr(8'h1C, 320); set_thr(8'h1E, 40); set_thr(8'h20, 380); set_thr(8'h22, -20);
    rd(8'h1C, tlo(320), "R3 high lo"); rd(8'h1D, thi(320), "R3 high hi");
    rd(8'h22, tlo(-20), "R3 lcrit lo"); rd(8'h23, thi(-20), "R3 lcrit hi");
    // R4 temperature word
    smp(100);
    rd(8'h31, 8'h90, "R4 temp lo"); rd(8'h32, 8'h01, "R4 temp hi");
    rd(8'h33, 8'h00, "R5 no alarm at 25C");
    // R5 boundary
    smp(320); rd(8'h33, 8'h00, "R5 equal to high");
    smp(321); rd(8'h33, 8'h01, "R5 above high");
    // R8 sticky
    smp(100); rd(8'h33, 8'h01, "R8 sticky high");
    wr(8'h13, 8'h01); rd(8'h33, 8'h00, "R9 clear high");
    // R7 critical, R9 reassert
    smp(384); rd(8'h33, 8'h05, "R7 crit high");
    wr(8'h13, 8'h04); rd(8'h33, 8'h01, "R9 partial clear");
    wr(8'h13, 8'h01); rd(8'h33, 8'h00, "R9 full clear");
    smp(384); rd(8'h33, 8'h05, "R9 reassert");
    wr(8'h13, 8'h0F);
    // R6 low boundary, R7 signed
    smp(40); rd(8'h33, 8'h00, "R6 equal to low");
    smp(39); rd(8'h33, 8'h02, "R6 below low");
    smp(-24); rd(8'h33, 8'h0A, "R7 crit low signed");
    rd(8'h31, 8'hA0, "R4 negative lo"); rd(8'h32, 8'h1F, "R4 negative hi");
    wr(8'h13, 8'h0F);
    rd(8'h13, 8'h00, "R9 clear reg reads 0"); rd(8'h14, 8'h00, "R9 error clear reads 0");
    rd(8'h33, 8'h00, "R9 all cleared");
    // full-scale
    smp(1023); rd(8'h31, 8'hFC, "R4 max lo"); rd(8'h32, 8'h0F, "R4 max hi");
    rd(8'h33, 8'h05, "R7 max sets high and crit");
    wr(8'h13, 8'h0F);
    smp(-1024); rd(8'h31, 8'h00, "R4 min lo"); rd(8'h32, 8'h10, "R4 min hi");
    rd(8'h33, 8'h0A, "R7 min sets low and lcrit");
    wr(8'h13, 8'h0F);
    // R10 disable
    wr(8'h1A, 8'hFF); rd(8'h1A, 8'h01, "R10 config readback");
    smp(384);
    rd(8'h31, 8'h00, "R10 temp held lo"); rd(8'h32, 8'h10, "R10 temp held hi");
    rd(8'h33, 8'h00, "R10 no alarm while disabled");
    wr(8'h1A, 8'h00); smp(384);
    rd(8'h33, 8'h05, "R10 enabled again");
    wr(8'h13, 8'h0F);
    // R11 ignored writes
    wr(8'h00, 8'hAA); rd(8'h00, 8'h51, "R11 type write ignored");
    wr(8'h05, 8'hFF); rd(8'h05, 8'h02, "R11 capability write ignored");
    wr(8'h31, 8'h55); rd(8'h31, tlo(384), "R11 temp write ignored");
    wr(8'h33, 8'hFF); rd(8'h33, 8'h00, "R11 status write ignored");
    wr(8'h40, 8'h77); rd(8'h40, 8'h00, "R11 unmapped read");
    rd(8'h1C, tlo(320), "R11 limits untouched");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule